// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block supervises software through a periodic restart. A single 8-bit control register holds a three-bit period select, an enable, a self-clearing restart bit and a data-pointer bank select that is only passed through to an output pin. While the watchdog is enabled and power-down is low, it counts pulses of a slow timebase tick. If the selected number of ticks goes by without a restart, it drives a reset pulse of fixed length. The count then starts again from zero.

The shortest period is `BASE_TICKS` ticks, which is 16 ticks by default, or 16 ms with a 1 ms tick. Each select code doubles the one below it, so code 7 gives 128 times the base. The register is written through a plain write strobe with data, and it can be read back at all times. No data stream passes through the block, so no valid/ready handshake applies.

Top module: `wdog_prescaled`

## Requirements
- R1: After power-on reset (`rst_n` low), `wd_rst_o` is 0, `dptr_sel_o` is 0, `ctl_rdata_o` reads 0x00, and the watchdog does not count.
- R2: The register layout is: bits 7:5 period select, bit 2 data-pointer select, bit 1 restart, bit 0 enable. Bits 4, 3 and 1 always read 0. `dptr_sel_o` equals the stored bit 2. As an example, writing 0xFF reads back 0xE5.
- R3: The period is `BASE_TICKS << sel` ticks. `wd_rst_o` rises at the clock edge after the edge that takes the tick completing the period.
- R4: A write with bit 1 set clears the count. A tick present at the clock edge right after that write is not counted. With a tick on every cycle, `wd_rst_o` therefore rises `(BASE_TICKS<<sel)+2` edges after the write edge.
- R5: Restart writes issued more often than once per period keep `wd_rst_o` low.
- R6: Only edges with `tick_i` high advance the count. With `tick_i` held low, no pulse occurs.
- R7: With the enable bit at 0, the count is held at zero and no pulse occurs.
- R8: While `pdown_i` is high, the count is held at zero and no pulse occurs. After `pdown_i` falls, a full period elapses before the next pulse: with a tick on every cycle, `wd_rst_o` rises `BASE_TICKS<<sel` edges after the first edge with `pdown_i` low.
- R9: Each expiry gives a pulse of exactly `PULSE_CYCLES` clock cycles and clears the count. If nothing changes, the next pulse rises `BASE_TICKS<<sel` tick-edges after the previous one.
- R10: A write that changes the period select clears the count, exactly as a restart does, even when bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle per tick |
| pdown_i | input | 1 | Power-down; stops and clears the watchdog |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| wd_rst_o | output | 1 | Internal reset pulse |
| dptr_sel_o | output | 1 | Data-pointer bank select bit |

## Verification
A register write takes effect at its own edge. The restart strobe acts one edge later, and the expiry goes through one more register before it reaches `wd_rst_o`. As a result, a restart write with a tick on every cycle raises the pulse `(BASE_TICKS<<sel)+2` edges after the write, and a release of power-down raises it `BASE_TICKS<<sel` edges after release. The bench drives inputs on falling edges and counts falling edges up to the first high `wd_rst_o`. It compares that count with these formulas for each select code, then counts the pulse width and the gap to the following pulse. Checks that something never happens sample `wd_rst_o` on every falling edge across windows much longer than the period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTL_W     = 8;
  localparam int SEL_W     = 3;
  localparam int SEL_LSB   = 5;
  localparam int DPS_BIT   = 2;
  localparam int KICK_BIT  = 1;
  localparam int EN_BIT    = 0;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             dps;
    logic             en;
  } wdog_ctl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output wdog_ctl_t        ctl_o,
  output logic             restart_o,
  output logic [CTL_W-1:0] rdata_o
);
  wdog_ctl_t        ctl_q;
  logic             restart_q;
  logic [SEL_W-1:0] wsel;

  assign wsel = wdata_i[SEL_LSB +: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      restart_q <= 1'b1;
    end else begin
      restart_q <= we_i & (wdata_i[KICK_BIT] | (wsel != ctl_q.sel));
      if (we_i) begin
        ctl_q.sel <= wsel;
        ctl_q.dps <= wdata_i[DPS_BIT];
        ctl_q.en  <= wdata_i[EN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o                     = '0;
    rdata_o[SEL_LSB +: SEL_W]   = ctl_q.sel;
    rdata_o[DPS_BIT]            = ctl_q.dps;
    rdata_o[EN_BIT]             = ctl_q.en;
  end

  assign ctl_o     = ctl_q;
  assign restart_o = restart_q;

  // R4
  kick_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_q && !we_i) |=> !restart_q);
  // R2
  kick_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[KICK_BIT] == 1'b0);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int CNT_W      = $clog2(BASE_TICKS) + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             last_tick;
  logic             exp_q;

  assign lim       = BASE_V << sel_i;
  assign last_tick = tick_i && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!active_i || restart_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (last_tick) begin
      cnt_q <= '0;
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(tick_i);
      exp_q <= 1'b0;
    end
  end

  assign expire_o = exp_q;

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !restart_i) |-> (cnt_q < lim));
  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0 && !exp_q));
  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !restart_i && !tick_i) |=> !exp_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYCLES = 4,
  parameter int PW           = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic pulse_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire_i)         left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  // R9
  fire_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> pulse_o);
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int BASE_TICKS   = 16,
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pdown_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic             wd_rst_o,
  output logic             dptr_sel_o
);
  localparam int CNT_W = $clog2(BASE_TICKS) + 8;

  wdog_ctl_t ctl;
  logic      restart;
  logic      active;
  logic      expire;

  wdog_ctrl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .ctl_o     (ctl),
    .restart_o (restart),
    .rdata_o   (ctl_rdata_o)
  );

  assign active = ctl.en & ~pdown_i;

  wdog_counter #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .active_i  (active),
    .restart_i (restart),
    .sel_i     (ctl.sel),
    .expire_o  (expire)
  );

  wdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (expire),
    .pulse_o (wd_rst_o)
  );

  assign dptr_sel_o = ctl.dps;

  // R8
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_i |=> !expire);
  // R2
  dps_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dptr_sel_o == ctl_rdata_o[DPS_BIT]);
endmodule

// File: tb/wdog_prescaled_tb_top.sv
module wdog_prescaled_tb_top;
  localparam int BASE = 4;
  localparam int PW   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       pdown = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       wdr;
  logic       dps;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  wdog_prescaled #(.BASE_TICKS(BASE), .PULSE_CYCLES(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pdown_i(pdown),
    .ctl_we_i(we), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata),
    .wd_rst_o(wdr), .dptr_sel_o(dps)
  );

  // {sel, expected edges from restart write to pulse rise} = (BASE<<sel)+2
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 16'd6},   {3'd1, 16'd10},  {3'd2, 16'd18},  {3'd3, 16'd34},
    {3'd4, 16'd66},  {3'd5, 16'd130}, {3'd6, 16'd258}, {3'd7, 16'd514}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rise_after(output int n);
    n = 0;
    while (!wdr && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wdr) highs++;
    end
  endtask

  initial begin
    int n, w, g, h;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdata == 8'h00, "R1 rdata", rdata, 0);
    chk(!wdr && !dps, "R1 outputs", {wdr, dps}, 0);
    rst_n = 1'b1;
    quiet(200, h);
    chk(h == 0, "R1 idle after reset", h, 0);

    // R2: layout and readback
    wr(8'hFF);
    chk(rdata == 8'hE5, "R2 readback", rdata, 8'hE5);
    chk(dps == 1'b1, "R2 dps out", dps, 1);
    wr(8'h00);
    chk(dps == 1'b0 && rdata == 8'h00, "R2 cleared", rdata, 0);

    // R3 R4 R9: table walk
    for (int k = 0; k < 8; k++) begin
      logic [2:0] s;
      int lat;
      s   = VEC[k][18:16];
      lat = int'(VEC[k][15:0]);
      wr({s, 5'b00011});
      n = n;
      rise_after(n);
      chk(n == lat, "R3 R4 period", n, lat);
      w = 0;
      while (wdr && w < 100) begin @(negedge clk); w++; end
      chk(w == PW, "R9 width", w, PW);
      g = 0;
      while (!wdr && g < 3000) begin @(negedge clk); g++; end
      chk(w + g == (BASE << s), "R9 repeat", w + g, BASE << s);
      wr(8'h00);
      repeat (PW + 2) @(negedge clk);
    end

    // R5: frequent restarts (sel=1, limit 8)
    wr(8'h23);
    h = 0;
    for (int i = 0; i < 60; i++) begin
      wr(8'h23);
      @(negedge clk); if (wdr) h++;
      @(negedge clk); if (wdr) h++;
    end
    chk(h == 0, "R5 kicked", h, 0);

    // R6: no ticks
    tick = 1'b0;
    quiet(400, h);
    chk(h == 0, "R6 no tick", h, 0);
    tick = 1'b1;
    rise_after(n);
    chk(n == 8, "R6 resumes", n, 8);
    wr(8'h00);
    repeat (PW + 2) @(negedge clk);

    // R7: enable low
    wr(8'h02);
    quiet(400, h);
    chk(h == 0, "R7 disabled", h, 0);

    // R8: power-down
    wr(8'h03);
    pdown = 1'b1;
    quiet(300, h);
    chk(h == 0, "R8 pdown quiet", h, 0);
    pdown = 1'b0;
    @(posedge clk);
    @(negedge clk);
    n = 0;
    rise_after(n);
    chk(n == BASE, "R8 full period after release", n, BASE);
    wr(8'h00);
    repeat (PW + 2) @(negedge clk);

    // R10: select change clears count
    wr(8'h23);
    repeat (6) @(negedge clk);
    wr(8'h41);
    rise_after(n);
    chk(n == 18, "R10 select change restart", n, 18);
    wr(8'h00);
    repeat (PW + 2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule